// File: doc/BRIEF.md
# Backlight PWM Generator with Step Prescaler

This block drives a display backlight with a pulse-width-modulated signal built from a fast reference clock. A prescaler turns the reference clock into step ticks, each 16 or 128 reference cycles long. A granularity input selects the step length. A step counter then runs through a programmed period and holds the output active for the first `duty` steps of each period. The output rate is the reference clock divided by the step length, then divided again by the period.

Software programs two 32-bit words through a plain write strobe. The timing word carries the period in its upper half and the duty in its lower half. The mode word carries run enable, a duty-source select and an output inversion bit. The duty can come from the timing word or from an alternate duty input, so another agent can own brightness while software owns frequency. The build-time parameter `REF_CLK_HZ` records which of the two supported reference clocks (24 MHz or 135 MHz) feeds the block. Elaboration rejects any other value.

Top module: `bl_pwm_gen`

## Requirements
- R1: A synchronous active-high reset clears both programmed words, which leaves the block stopped, non-inverted and with period 0, and drives `pwm_out` low on the next clock.
- R2: A write with `wr_sel`=1 loads the timing word: bits 31:16 are the period in steps and bits 15:0 are the duty in steps. A write with `wr_sel`=0 loads the mode word from bits 31 (run), 30 (register-duty select) and 29 (invert).
- R3: Each step lasts 16 reference cycles while `fine_step` is 1 and 128 reference cycles while it is 0.
- R4: With period P, rising edges of the non-inverted output are P × step-length cycles apart.
- R5: In each period the non-inverted output is high for exactly duty × step-length cycles.
- R6: A duty greater than or equal to the period keeps the output active for the whole period. A duty of 0 keeps it inactive.
- R7: A period of 0 keeps the output inactive, and the step counter stays at 0.
- R8: With mode bit 29 set, the output is the exact inverse of the non-inverted waveform.
- R9: While mode bit 31 is clear, the output sits at its inactive level (high when inverted, low otherwise) from the second clock after the write, and the prescaler and step counter are held at 0.
- R10: With mode bit 30 set, the duty is taken from the timing word and `alt_duty` is ignored. With the bit clear, `alt_duty` is used.
- R11: While running, a new period, duty or duty source takes effect only at the next period boundary, so the output cycle in progress completes with the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one word |
| wr_sel | input | 1 | 0 selects the mode word, 1 selects the timing word |
| wr_data | input | 32 | Write data |
| fine_step | input | 1 | 1: 16-cycle steps, 0: 128-cycle steps |
| alt_duty | input | 16 | Duty in steps, used when register duty is not selected |
| pwm_out | output | 1 | Backlight PWM output |

## Verification
If the prescaler or step counter holds a wrong value, the total high time and the spacing between rising edges go wrong within one output period. The bench measures both over whole periods, so the phase at which a test starts does not affect the result. A shadow register that picks up new values too early shows up as a shortened gap in the very period during which the write lands. A stale enable or inversion state shows up at the output two clocks after the mode write.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
    // Mode word bit positions
    localparam int MODE_RUN_BIT = 31;
    localparam int MODE_REG_DUTY_BIT = 30;
    localparam int MODE_INVERT_BIT = 29;
    // Timing word field positions
    localparam int TIME_PER_LSB = 16;
    localparam int FIELD_W = 16;

    typedef struct packed {
        logic run;
        logic reg_duty;
        logic invert;
    } mode_t;

    typedef struct packed {
        logic [FIELD_W-1:0] period;
        logic [FIELD_W-1:0] duty;
    } timing_t;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
    import bl_pwm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [31:0] wr_data,
    output mode_t       mode,
    output timing_t     timing
);
    typedef struct packed {
        mode_t   mode;
        timing_t timing;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (wr_sel) begin
                regs_d.timing.period = wr_data[TIME_PER_LSB +: FIELD_W];
                regs_d.timing.duty   = wr_data[FIELD_W-1:0];
            end else begin
                regs_d.mode.run      = wr_data[MODE_RUN_BIT];
                regs_d.mode.reg_duty = wr_data[MODE_REG_DUTY_BIT];
                regs_d.mode.invert   = wr_data[MODE_INVERT_BIT];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '0;
        else     regs_q <= regs_d;
    end

    assign mode   = regs_q.mode;
    assign timing = regs_q.timing;
endmodule

// File: rtl/bl_pwm_prescaler.sv
module bl_pwm_prescaler #(
    parameter int FINE_STEP   = 16,
    parameter int COARSE_STEP = 128,
    localparam int PRE_W = $clog2(COARSE_STEP)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             fine_step,
    output logic             tick,
    output logic [PRE_W-1:0] pre_cnt
);
    localparam logic [PRE_W-1:0] FINE_LAST   = PRE_W'(FINE_STEP - 1);
    localparam logic [PRE_W-1:0] COARSE_LAST = PRE_W'(COARSE_STEP - 1);

    logic [PRE_W-1:0] cnt_d, cnt_q;
    logic [PRE_W-1:0] last;

    always_comb begin
        last = fine_step ? FINE_LAST : COARSE_LAST;
        // ">=" lets a switch to the short step end a long count at once
        tick = run && (cnt_q >= last);
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign pre_cnt = cnt_q;
endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             invert,
    input  logic             reg_duty,
    input  logic [CNT_W-1:0] per_prog,
    input  logic [CNT_W-1:0] duty_prog,
    input  logic [CNT_W-1:0] alt_duty,
    input  logic             tick,
    output logic             pwm,
    output logic             wrap,
    output logic [CNT_W-1:0] step_cnt,
    output logic [CNT_W-1:0] per_act
);
    typedef struct packed {
        logic [CNT_W-1:0] step;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] duty;
        logic             pwm;
    } core_t;

    core_t core_d, core_q;
    logic [CNT_W-1:0] duty_sel;
    logic             at_end;
    logic             active;

    always_comb begin
        core_d   = core_q;
        duty_sel = reg_duty ? duty_prog : alt_duty;
        at_end   = (core_q.per == '0) || (core_q.step == core_q.per - 1'b1);
        wrap     = run && tick && at_end;
        active   = run && (core_q.per != '0) && (core_q.step < core_q.duty);

        if (!run) begin
            // stopped: counter parked, shadows follow the programmed values
            core_d.step = '0;
            core_d.per  = per_prog;
            core_d.duty = duty_sel;
        end else if (tick) begin
            if (at_end) begin
                core_d.step = '0;
                core_d.per  = per_prog;
                core_d.duty = duty_sel;
            end else begin
                core_d.step = core_q.step + 1'b1;
            end
        end
        core_d.pwm = active ^ invert;
    end

    always_ff @(posedge clk) begin
        if (rst) core_q <= '0;
        else     core_q <= core_d;
    end

    assign pwm      = core_q.pwm;
    assign step_cnt = core_q.step;
    assign per_act  = core_q.per;
endmodule

// File: rtl/bl_pwm_gen.sv
module bl_pwm_gen
    import bl_pwm_pkg::*;
#(
    parameter int REF_CLK_HZ  = 24_000_000,
    parameter int FINE_STEP   = 16,
    parameter int COARSE_STEP = 128,
    localparam int CNT_W = FIELD_W,
    localparam int PRE_W = $clog2(COARSE_STEP)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [31:0]      wr_data,
    input  logic             fine_step,
    input  logic [CNT_W-1:0] alt_duty,
    output logic             pwm_out
);
    generate
        if (REF_CLK_HZ != 24_000_000 && REF_CLK_HZ != 135_000_000) begin : g_bad_ref
            $error("REF_CLK_HZ must be 24 MHz or 135 MHz");
        end
    endgenerate

    mode_t            mode;
    timing_t          timing;
    logic             run;
    logic             pol;
    logic             tick;
    logic             wrap;
    logic [PRE_W-1:0] pre_cnt;
    logic [CNT_W-1:0] step_cnt;
    logic [CNT_W-1:0] per_act;

    assign run = mode.run;
    assign pol = mode.invert;

    bl_pwm_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .mode    (mode),
        .timing  (timing)
    );

    bl_pwm_prescaler #(
        .FINE_STEP   (FINE_STEP),
        .COARSE_STEP (COARSE_STEP)
    ) u_pre (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .fine_step (fine_step),
        .tick      (tick),
        .pre_cnt   (pre_cnt)
    );

    bl_pwm_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .invert    (pol),
        .reg_duty  (mode.reg_duty),
        .per_prog  (timing.period),
        .duty_prog (timing.duty),
        .alt_duty  (alt_duty),
        .tick      (tick),
        .pwm       (pwm_out),
        .wrap      (wrap),
        .step_cnt  (step_cnt),
        .per_act   (per_act)
    );
endmodule

// File: rtl/bl_pwm_checks.sv
module bl_pwm_checks #(
    parameter int CNT_W = 16,
    parameter int PRE_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             pol,
    input logic             tick,
    input logic             wrap,
    input logic [PRE_W-1:0] pre_cnt,
    input logic [CNT_W-1:0] step_cnt,
    input logic [CNT_W-1:0] per_act,
    input logic             pwm_out
);
    assert_reset_low_R1: assert property (@(posedge clk)
        rst |=> !pwm_out);

    assert_tick_gated_R3: assert property (@(posedge clk) disable iff (rst)
        tick |-> run);

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        (per_act != '0) |-> (step_cnt < per_act));

    assert_zero_period_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (per_act == '0) |-> (step_cnt == '0));

    assert_zero_period_out_R7: assert property (@(posedge clk) disable iff (rst)
        (run && per_act == '0) |=> (pwm_out == $past(pol)));

    assert_stopped_level_R9: assert property (@(posedge clk) disable iff (rst)
        !run |=> (pwm_out == $past(pol)));

    assert_stopped_counters_R9: assert property (@(posedge clk) disable iff (rst)
        !run |=> (pre_cnt == '0 && step_cnt == '0));

    assert_shadow_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && !$past(wrap)) |-> $stable(per_act));
endmodule

bind bl_pwm_gen bl_pwm_checks #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .pol      (pol),
    .tick     (tick),
    .wrap     (wrap),
    .pre_cnt  (pre_cnt),
    .step_cnt (step_cnt),
    .per_act  (per_act),
    .pwm_out  (pwm_out)
);

// File: tb/sim_bl_pwm_gen.sv
`timescale 1ns/1ps
module sim_bl_pwm_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        fine_step = 1'b1;
    logic [15:0] alt_duty = '0;
    logic        pwm_out;

    int n_checks = 0;
    int n_fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bl_pwm_gen u0 (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .fine_step (fine_step),
        .alt_duty  (alt_duty),
        .pwm_out   (pwm_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    // mode word: bit31 run, bit30 register duty, bit29 invert
    task automatic wr_mode(input bit run, input bit regd, input bit inv);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = {run, regd, inv, 29'b0};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // timing word: period in 31:16, duty in 15:0
    task automatic wr_time(input int per, input int duty);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = {per[15:0], duty[15:0]};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic setup(input int per, input int duty, input bit fine,
                         input bit regd, input bit inv);
        wr_mode(1'b0, regd, inv);
        wr_time(per, duty);
        fine_step = fine;
        wr_mode(1'b1, regd, inv);
        repeat (2 * per * (fine ? 16 : 128) + 10) @(negedge clk);
    endtask

    task automatic count_high(input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (pwm_out) n++;
        end
    endtask

    task automatic wait_rise();
        logic prev;
        prev = pwm_out;
        forever begin
            @(negedge clk);
            if (pwm_out && !prev) break;
            prev = pwm_out;
        end
    endtask

    task automatic wait_fall();
        logic prev;
        prev = pwm_out;
        forever begin
            @(negedge clk);
            if (!pwm_out && prev) break;
            prev = pwm_out;
        end
    endtask

    // length of the current level run, counting the present sample
    task automatic run_len(output int n);
        logic lvl;
        lvl = pwm_out;
        n = 1;
        forever begin
            @(negedge clk);
            if (pwm_out != lvl) break;
            n++;
        end
    endtask

    task automatic t_reset();
        int n;
        chk("R1 output low after reset", int'(pwm_out), 0);
        count_high(200, n);
        chk("R1 idle after reset", n, 0);
    endtask

    task automatic t_stopped();
        int n;
        wr_time(10, 3);
        wr_mode(1'b0, 1'b1, 1'b1);
        count_high(300, n);
        chk("R9 stopped inverted level high", n, 300);
        wr_mode(1'b0, 1'b1, 1'b0);
        count_high(300, n);
        chk("R9 stopped plain level low", n, 0);
    endtask

    task automatic t_fine();
        int n;
        setup(10, 3, 1'b1, 1'b1, 1'b0);
        count_high(320, n);
        chk("R2 R5 fine duty 3 of 10", n, 96);
        wait_rise();
        run_len(n);
        chk("R5 single pulse width", n, 48);
        wait_rise();
        n = 0;
        wait_rise_count(n);
        chk("R4 fine period spacing", n, 160);
    endtask

    task automatic wait_rise_count(output int n);
        logic prev;
        prev = pwm_out;
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (pwm_out && !prev) break;
            prev = pwm_out;
        end
    endtask

    task automatic t_coarse();
        int n;
        setup(4, 1, 1'b0, 1'b1, 1'b0);
        count_high(1024, n);
        chk("R3 coarse step high time", n, 256);
        wait_rise();
        wait_rise_count(n);
        chk("R3 R4 coarse period spacing", n, 512);
    endtask

    task automatic t_invert();
        int n;
        setup(10, 3, 1'b1, 1'b1, 1'b1);
        count_high(320, n);
        chk("R8 inverted high time", n, 224);
    endtask

    task automatic t_duty_edges();
        int n;
        setup(10, 12, 1'b1, 1'b1, 1'b0);
        count_high(320, n);
        chk("R6 duty above period always on", n, 320);
        setup(10, 10, 1'b1, 1'b1, 1'b0);
        count_high(320, n);
        chk("R6 duty equal period always on", n, 320);
        setup(10, 0, 1'b1, 1'b1, 1'b0);
        count_high(320, n);
        chk("R6 duty zero never on", n, 0);
    endtask

    task automatic t_zero_period();
        int n;
        setup(0, 5, 1'b1, 1'b1, 1'b0);
        count_high(400, n);
        chk("R7 zero period inactive", n, 0);
    endtask

    task automatic t_source();
        int n;
        alt_duty = 16'd5;
        setup(10, 3, 1'b1, 1'b0, 1'b0);
        count_high(320, n);
        chk("R10 alternate duty used", n, 160);
        wr_mode(1'b1, 1'b1, 1'b0);
        alt_duty = 16'd9;
        repeat (340) @(negedge clk);
        count_high(320, n);
        chk("R10 register duty, alt ignored", n, 96);
    endtask

    task automatic t_boundary();
        int n;
        setup(10, 5, 1'b1, 1'b1, 1'b0);
        wait_fall();
        // write new timing during the low part of the current period
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = {16'd20, 16'd2};
        n = 1;
        @(negedge clk);
        wr_en = 1'b0;
        while (!pwm_out) begin
            n++;
            @(negedge clk);
        end
        chk("R11 old period completes", n, 80);
        run_len(n);
        chk("R11 new duty after boundary", n, 32);
        run_len(n);
        chk("R11 new period after boundary", n, 288);
    endtask

    task automatic t_stop_latency();
        setup(10, 5, 1'b1, 1'b1, 1'b0);
        wait_rise();
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = {1'b0, 1'b1, 1'b1, 29'b0};
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        chk("R9 stop reaches inactive level", int'(pwm_out), 1);
        wr_mode(1'b0, 1'b1, 1'b0);
        @(negedge clk);
        chk("R9 stop plain level", int'(pwm_out), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_stopped();
        t_fine();
        t_coarse();
        t_invert();
        t_duty_edges();
        t_zero_period();
        t_source();
        t_boundary();
        t_stop_latency();
        report();
    end
endmodule